// File: doc/BRIEF.md
# Fill-Level Driven Clock and Voltage Step Controller

This block chooses the operating point of one clock and supply domain. It watches the occupancy count of a buffer that sits between this domain and its neighbour, compares that count with a reference level, and moves a frequency code and a paired voltage code up or down one step at a time. The two codes go to an external clock generator and regulator. A one-cycle pulse marks every cycle in which either code has just changed.

The count is judged only once per programmable sample interval. A level well below the reference means the domain is falling behind, so it speeds up. A level well above the reference means it can slow down. A level within one entry of the reference leaves the setting alone. Changes are ordered to keep the supply safe. On the way up the voltage moves first and the frequency follows after a programmable settle delay. On the way down the frequency drops at once and the voltage follows after the same delay. Buffer depth, the number of frequency steps and the shape of the voltage map are parameters, so one design serves domains with different buffers and different frequency ceilings.

Top module: `dvfs_fill_ctrl`

## Requirements
- R1: While reset is active, and after it is released, the frequency code starts at its top value FREQ_LEVELS-1 and the voltage code starts at the table value for that code. The change strobe is low.
- R2: Decisions are taken only on decision edges. These are the clock edges numbered k·max(sample_period,1) after reset is released, where the first edge with reset inactive is edge 1. At no other edge does a new step start.
- R3: On a decision edge where fill_level lies between ref_level-1 and ref_level+1 inclusive, neither code changes.
- R4: On a decision edge where fill_level+1 < ref_level and the frequency code is below its top value, the voltage code becomes the table value for the frequency code plus one. The frequency code does not change on that edge.
- R5: The frequency code then rises by one exactly settle_cycles+1 edges after that voltage change.
- R6: On a decision edge where fill_level > ref_level+1 and the frequency code is above zero, the frequency code drops by one. The voltage code does not change on that edge.
- R7: The voltage code then drops to the table value of the new frequency code exactly settle_cycles+1 edges later.
- R8: The frequency code saturates: it never goes below 0 or above FREQ_LEVELS-1. A request to move past either end changes nothing.
- R9: Any decision edge that falls while a settle delay is still pending is discarded.
- R10: code_change is high for exactly those cycles in which freq_code or volt_code differs from its value in the cycle before.
- R11: With the default linear map, the voltage table value for frequency code c is V_MIN + c·V_STEP, which is 20 + 3c for the defaults. With the paired map (VOLT_CURVE=1), it is V_MIN + 2·V_STEP·((c+1)/2), using integer division.
- R12: volt_code is never below the table value for the current freq_code, and the frequency code moves by at most one per edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_level | input | $clog2(FIFO_DEPTH+1) | Occupancy count of the watched buffer |
| ref_level | input | $clog2(FIFO_DEPTH+1) | Target occupancy |
| sample_period | input | SAMPLE_W | Cycles between decisions (0 is treated as 1) |
| settle_cycles | input | SETTLE_W | Settle delay minus one, in cycles |
| freq_code | output | $clog2(FREQ_LEVELS) | Frequency step sent to the clock generator |
| volt_code | output | VOLT_W | Supply step sent to the regulator |
| code_change | output | 1 | One-cycle pulse when either code has just changed |

## Verification
A corrupted sample counter shows at the ports as a step that lands on the wrong edge. This becomes visible at the first decision after reset, no later than sample_period cycles in. A settle counter or phase register holding the wrong value shows up as a second code change arriving too early or too late, or as a decision taken during a pending wait. A wrong voltage lookup or a misordered step leaves volt_code below the table value for freq_code for at least one cycle. These are all caught on the cycle they happen, because the bench predicts both codes and the strobe for every single cycle.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

   typedef enum logic [1:0] {
      PH_HOLD    = 2'd0,
      PH_UP_WAIT = 2'd1,
      PH_DN_WAIT = 2'd2
   } dvfs_phase_e;

   // table value of one frequency step for the selected curve
   function automatic int volt_of(input int code, input int vmin,
                                  input int vstep, input int curve);
      if (curve == 0) return vmin + code * vstep;
      return vmin + ((code + 1) / 2) * 2 * vstep;
   endfunction

endpackage

// File: rtl/dvfs_tick_gen.sv
module dvfs_tick_gen #(
   parameter int SAMPLE_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] period,
   output logic                tick
);
   logic [SAMPLE_W-1:0] cnt_q;
   logic [SAMPLE_W:0]   cnt_inc;

   assign cnt_inc = {1'b0, cnt_q} + (SAMPLE_W+1)'(1);
   assign tick    = (cnt_inc >= {1'b0, period});

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + SAMPLE_W'(1);
   end

   // R2
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && period > SAMPLE_W'(1)) |=> !tick);
endmodule

// File: rtl/dvfs_volt_map.sv
module dvfs_volt_map #(
   parameter int FC_W       = 3,
   parameter int VOLT_W     = 6,
   parameter int V_MIN      = 20,
   parameter int V_STEP     = 3,
   parameter int VOLT_CURVE = 0
) (
   input  logic [FC_W-1:0]   code,
   output logic [VOLT_W-1:0] volt
);
   logic [FC_W:0] code_w;
   assign code_w = {1'b0, code};

   if (VOLT_CURVE == 0) begin : g_linear
      assign volt = VOLT_W'(V_MIN + int'(code_w) * V_STEP);
   end else begin : g_paired
      logic [FC_W:0] pair_idx;
      assign pair_idx = (code_w + (FC_W+1)'(1)) >> 1;
      assign volt = VOLT_W'(V_MIN + int'(pair_idx) * 2 * V_STEP);
   end
endmodule

// File: rtl/dvfs_step_fsm.sv
module dvfs_step_fsm
   import dvfs_pkg::*;
#(
   parameter int LVL_W    = 6,
   parameter int FC_W     = 3,
   parameter int FC_TOP   = 7,
   parameter int VOLT_W   = 6,
   parameter int V_RESET  = 41,
   parameter int SETTLE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic [LVL_W-1:0]    fill,
   input  logic [LVL_W-1:0]    ref_lvl,
   input  logic [SETTLE_W-1:0] settle,
   input  logic [VOLT_W-1:0]   volt_now,
   input  logic [VOLT_W-1:0]   volt_next_up,
   output logic [FC_W-1:0]     freq_q,
   output logic [VOLT_W-1:0]   volt_q,
   output logic                change_q
);
   localparam logic [FC_W-1:0] TOP = FC_W'(FC_TOP);

   dvfs_phase_e         phase_q, phase_d;
   logic [SETTLE_W-1:0] wait_q, wait_d;
   logic [FC_W-1:0]     freq_d;
   logic [VOLT_W-1:0]   volt_d;
   logic                fill_high, fill_low;

   assign fill_high = {1'b0, fill} > ({1'b0, ref_lvl} + (LVL_W+1)'(1));
   assign fill_low  = ({1'b0, fill} + (LVL_W+1)'(1)) < {1'b0, ref_lvl};

   always_comb begin
      phase_d = phase_q;
      wait_d  = wait_q;
      freq_d  = freq_q;
      volt_d  = volt_q;
      unique case (phase_q)
         PH_HOLD: begin
            if (tick && fill_low && freq_q != TOP) begin
               volt_d  = volt_next_up;
               wait_d  = settle;
               phase_d = PH_UP_WAIT;
            end else if (tick && fill_high && freq_q != '0) begin
               freq_d  = freq_q - FC_W'(1);
               wait_d  = settle;
               phase_d = PH_DN_WAIT;
            end
         end
         PH_UP_WAIT: begin
            if (wait_q == '0) begin
               freq_d  = freq_q + FC_W'(1);
               phase_d = PH_HOLD;
            end else begin
               wait_d = wait_q - SETTLE_W'(1);
            end
         end
         PH_DN_WAIT: begin
            if (wait_q == '0) begin
               volt_d  = volt_now;
               phase_d = PH_HOLD;
            end else begin
               wait_d = wait_q - SETTLE_W'(1);
            end
         end
         default: phase_d = PH_HOLD;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= PH_HOLD;
         wait_q   <= '0;
         freq_q   <= TOP;
         volt_q   <= VOLT_W'(V_RESET);
         change_q <= 1'b0;
      end else begin
         phase_q  <= phase_d;
         wait_q   <= wait_d;
         freq_q   <= freq_d;
         volt_q   <= volt_d;
         change_q <= (freq_d != freq_q) || (volt_d != volt_q);
      end
   end

   // R12
   volt_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      volt_q >= volt_now);
   // R12
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_q == $past(freq_q)) || (freq_q == $past(freq_q) + FC_W'(1)) ||
      (freq_q + FC_W'(1) == $past(freq_q)));
   // R4
   one_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !((freq_q != $past(freq_q)) && (volt_q != $past(volt_q))));
   // R8
   freq_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      freq_q <= TOP);
   // R3
   dead_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && phase_q == PH_HOLD && !fill_high && !fill_low)
      |=> ($stable(freq_q) && $stable(volt_q)));
   // R10
   strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      change_q == ((freq_q != $past(freq_q)) || (volt_q != $past(volt_q))));
endmodule

// File: rtl/dvfs_fill_ctrl.sv
module dvfs_fill_ctrl
   import dvfs_pkg::*;
#(
   parameter int FIFO_DEPTH  = 32,
   parameter int FREQ_LEVELS = 8,
   parameter int VOLT_W      = 6,
   parameter int V_MIN       = 20,
   parameter int V_STEP      = 3,
   parameter int VOLT_CURVE  = 0,
   parameter int SAMPLE_W    = 12,
   parameter int SETTLE_W    = 8,
   localparam int LVL_W      = $clog2(FIFO_DEPTH + 1),
   localparam int FC_W       = $clog2(FREQ_LEVELS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [LVL_W-1:0]    fill_level,
   input  logic [LVL_W-1:0]    ref_level,
   input  logic [SAMPLE_W-1:0] sample_period,
   input  logic [SETTLE_W-1:0] settle_cycles,
   output logic [FC_W-1:0]     freq_code,
   output logic [VOLT_W-1:0]   volt_code,
   output logic                code_change
);
   localparam int FC_TOP  = FREQ_LEVELS - 1;
   localparam int V_RESET = volt_of(FC_TOP, V_MIN, V_STEP, VOLT_CURVE);
   localparam int V_BOUND = V_MIN + FREQ_LEVELS * V_STEP;

   if (FIFO_DEPTH < 2) begin : g_bad_depth
      $error("FIFO_DEPTH must be at least 2");
   end
   if (FREQ_LEVELS < 2) begin : g_bad_levels
      $error("FREQ_LEVELS must be at least 2");
   end
   if (V_BOUND >= (1 << VOLT_W)) begin : g_bad_volt
      $error("voltage table exceeds VOLT_W");
   end
   if (VOLT_CURVE != 0 && VOLT_CURVE != 1) begin : g_bad_curve
      $error("VOLT_CURVE must be 0 or 1");
   end

   logic              tick;
   logic [FC_W-1:0]   freq_up;
   logic [VOLT_W-1:0] volt_now, volt_up;

   assign freq_up = freq_code + FC_W'(1);

   dvfs_tick_gen #(.SAMPLE_W(SAMPLE_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .period(sample_period), .tick(tick));

   dvfs_volt_map #(.FC_W(FC_W), .VOLT_W(VOLT_W), .V_MIN(V_MIN),
                   .V_STEP(V_STEP), .VOLT_CURVE(VOLT_CURVE)) u_map_now (
      .code(freq_code), .volt(volt_now));

   dvfs_volt_map #(.FC_W(FC_W), .VOLT_W(VOLT_W), .V_MIN(V_MIN),
                   .V_STEP(V_STEP), .VOLT_CURVE(VOLT_CURVE)) u_map_up (
      .code(freq_up), .volt(volt_up));

   dvfs_step_fsm #(.LVL_W(LVL_W), .FC_W(FC_W), .FC_TOP(FC_TOP),
                   .VOLT_W(VOLT_W), .V_RESET(V_RESET),
                   .SETTLE_W(SETTLE_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .fill(fill_level), .ref_lvl(ref_level), .settle(settle_cycles),
      .volt_now(volt_now), .volt_next_up(volt_up),
      .freq_q(freq_code), .volt_q(volt_code), .change_q(code_change));

   // R1
   reset_top_chk: assert property (@(posedge clk)
      !rst_n |=> (freq_code == FC_W'(FC_TOP) && !code_change));
endmodule

// File: tb/dvfs_fill_ctrl_test.sv
module dvfs_fill_ctrl_test;
   localparam int TOPC = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] fill = '0, refl = 6'd16;
   logic [11:0] per = 12'd8;
   logic [7:0] stl = 8'd3;
   logic [2:0] freq;
   logic [5:0] volt;
   logic       chg;

   int checks = 0, fails = 0;
   bit model_on = 0, done = 0;
   int cyc, pend, exp_f, exp_v, prev_f, prev_v;
   bit go_up;

   always #10 clk = ~clk;

   dvfs_fill_ctrl uut (.clk(clk), .rst_n(rst_n), .fill_level(fill),
      .ref_level(refl), .sample_period(per), .settle_cycles(stl),
      .freq_code(freq), .volt_code(volt), .code_change(chg));

   function automatic int vt(input int c);
      return 20 + 3 * c;
   endfunction

   task automatic check(input string tag, input string what,
                        input int got, input int expv);
      checks++;
      if (got != expv) begin
         fails++;
         $display("FAIL %s %s cycle %0d: got %0d expected %0d",
                  tag, what, cyc, got, expv);
      end
   endtask

   // per-cycle prediction from the requirements
   always @(negedge clk) begin
      if (model_on) begin
         string why;
         int peff, f_in, r_in;
         cyc++;
         peff = (per == 0) ? 1 : int'(per);
         f_in = int'(fill);
         r_in = int'(refl);
         prev_f = exp_f;
         prev_v = exp_v;
         if (pend > 0) begin
            pend--;
            if (pend == 0) begin
               if (go_up) begin exp_f++; why = "R5"; end
               else begin exp_v = vt(exp_f); why = "R7"; end
            end else why = "R9";
         end else if ((cyc % peff) != 0) begin
            why = "R2";
         end else if (f_in > r_in + 1) begin
            if (exp_f > 0) begin
               exp_f--; pend = int'(stl) + 1; go_up = 0; why = "R6";
            end else why = "R8";
         end else if (f_in + 1 < r_in) begin
            if (exp_f < TOPC) begin
               exp_v = vt(exp_f + 1); pend = int'(stl) + 1; go_up = 1; why = "R4";
            end else why = "R8";
         end else why = "R3";
         check(why, "freq_code", int'(freq), exp_f);
         check(why, "volt_code", int'(volt), exp_v);
         check("R10", "code_change", int'(chg),
               int'((exp_f != prev_f) || (exp_v != prev_v)));
         check("R12", "volt floor", int'(int'(volt) >= vt(int'(freq))), 1);
      end
   end

   task automatic start(input int p, input int s, input int r, input int f);
      model_on = 0;
      @(negedge clk);
      rst_n = 1'b0;
      per = 12'(p); stl = 8'(s); refl = 6'(r); fill = 6'(f);
      repeat (3) @(negedge clk);
      cyc = 0;
      check("R1", "reset freq", int'(freq), TOPC);
      check("R11", "reset volt", int'(volt), vt(TOPC));
      check("R1", "reset strobe", int'(chg), 0);
      #2;
      rst_n = 1'b1;
      exp_f = TOPC; exp_v = vt(TOPC); pend = 0; go_up = 0;
      model_on = 1;
   endtask

   task automatic hold(input int f, input int n);
      @(negedge clk);
      #1 fill = 6'(f);
      repeat (n - 1) @(negedge clk);
   endtask

   task automatic rand_run(input int n, input int r);
      for (int i = 0; i < n; i++) begin
         int f;
         if ($urandom_range(0, 2) == 0) f = $urandom_range(0, 32);
         else f = r - 3 + $urandom_range(0, 6);
         if (f < 0) f = 0;
         if (f > 32) f = 32;
         @(negedge clk);
         #1 fill = 6'(f);
      end
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete");
         $display("End of test - %0d assertions evaluated, %0d failures",
                  checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1357));
      // slow-down to the floor, R6/R7/R8, first step on edge 8 (R2)
      start(8, 3, 16, 30);
      repeat (7) @(negedge clk);
      #1 check("R2", "no step before edge 8", int'(freq), TOPC);
      @(negedge clk);
      #1 check("R6", "first drop on edge 8", int'(freq), TOPC - 1);
      hold(30, 120);
      check("R8", "floor reached", int'(freq), 0);
      check("R7", "floor voltage", int'(volt), vt(0));
      // speed-up to the ceiling, R4/R5/R8
      hold(0, 150);
      check("R8", "ceiling reached", int'(freq), TOPC);
      check("R11", "ceiling voltage", int'(volt), vt(TOPC));
      // dead band from a middle code, R3
      hold(30, 20);
      for (int i = 0; i < 30; i++) hold(15 + (i % 3), 1);
      // every-cycle sampling, zero settle
      start(0, 0, 10, 10);
      rand_run(800, 10);
      // settle longer than interval, R9
      start(5, 9, 20, 28);
      rand_run(1500, 20);
      start(3, 2, 6, 0);
      rand_run(1500, 6);
      for (int k = 0; k < 6; k++) begin
         int r = $urandom_range(2, 30);
         start($urandom_range(1, 12), $urandom_range(0, 15), r, r);
         rand_run(500, r);
      end
      model_on = 0;
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures",
               checks, fails);
      $finish;
   end
endmodule